// File: doc/BRIEF.md
# Serial Framing-Code Detector with Byte Timing

This block sits behind a data slicer. It takes one serial bit on each bit-clock cycle and shifts it into an 8-bit register. It then compares that register with a programmable 8-bit synchronisation pattern. A line starts with two clock run-in bytes, followed by the pattern as its third byte. When the pattern is seen inside the validation window, the block emits a one-cycle line-start pulse for the downstream sequencer. At the same moment it restarts a modulo-8 bit counter, so every following group of eight bits is presented as a parallel byte with a one-cycle strobe.

A hit is accepted when at least seven of the eight bits agree with the pattern, so a single slicing error does not lose the line. After a hit, the detector is disarmed so that payload bytes which happen to look like the pattern cannot restart the byte timing. It is armed again by an end-of-line pulse or by a fresh opening of the window. The end-of-line pulse also stops the byte strobes.

Top module: `frame_sync_rx`

## Requirements
- R1: While rst_ni is low, line_start_o and byte_vld_o are 0 and byte_o is 0.
- R2: Bits are taken least significant first: the earliest of the eight bits forming a byte appears on byte_o bit 0, the latest on bit 7.
- R3: When the 8-bit register equals code_i exactly while win_i is high and the detector is armed, line_start_o is high for exactly the next cycle.
- R4: A hit needs at least 7 agreeing bit positions: a pattern with one flipped bit (any position) is detected, one with two flipped bits is not.
- R5: No line-start pulse follows a cycle in which win_i is low.
- R6: After a hit the detector is disarmed. A later pattern is delivered as an ordinary byte and not as a line start, until eol_i is high or win_i goes from low to high.
- R7: byte_vld_o is a one-cycle pulse. The first one comes 7 cycles after line_start_o, and later ones come every 8 cycles.
- R8: A cycle with eol_i high and no hit stops byte timing: no byte strobe follows it until the next hit.
- R9: A window opening (win_i low in the previous cycle, high now) re-arms the detector in the same cycle, so a pattern present in that cycle is detected.
- R10: A hit while bytes are already being timed re-phases the counter and drops the partial byte in progress. An eol_i pulse in the cycle of the hit re-arms and detects, and does not stop the new line.
- R11: byte_o only changes together with a byte_vld_o pulse and holds its value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one serial bit per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_i | input | 1 | Serial data bit |
| win_i | input | 1 | Validation window for pattern search |
| eol_i | input | 1 | End-of-line pulse: re-arms detection, stops byte timing |
| code_i | input | W (8) | Programmable synchronisation pattern |
| line_start_o | output | 1 | One-cycle pulse after a detected pattern |
| byte_vld_o | output | 1 | One-cycle strobe, byte_o holds a new byte |
| byte_o | output | W (8) | Assembled parallel byte |

## Verification
A hit can share its cycle with a re-arm event, and it can also share a cycle with the byte counter of an earlier line that is still running. Both cases are driven on purpose. In one, the pattern completes while the window is low, and the window then rises in the very next bit, which is the cycle the register holds the pattern. In the other, three filler bits knock the pattern off the old byte grid, and an end-of-line pulse is aligned to the cycle of the hit. The scoreboard judges both cases by the order of events: the old-phase byte, then the line start, then new-phase bytes at 7 and 8 cycle spacing. Exact byte values are checked, with no stray or missing strobe.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/fsync_shift.sv
module fsync_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sd_i,
  output logic [W-1:0] sr_o,
  output logic [W-1:0] sr_nxt_o
);
  // newest bit enters at the top, so the oldest ends in bit 0
  assign sr_nxt_o = {sd_i, sr_o[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_o <= '0;
    else         sr_o <= sr_nxt_o;
  end
endmodule

// File: rtl/fsync_match.sv
module fsync_match #(
  parameter int unsigned W         = 8,
  parameter int unsigned MIN_AGREE = W - 1
) (
  input  logic [W-1:0] sr_i,
  input  logic [W-1:0] code_i,
  output logic         hit_o
);
  localparam int unsigned PW = $clog2(W + 1);

  logic [W-1:0]  agree;
  logic [PW-1:0] n_agree;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign agree[g] = ~(sr_i[g] ^ code_i[g]);
  end

  always_comb begin
    n_agree = '0;
    for (int i = 0; i < W; i++) n_agree = n_agree + PW'(agree[i]);
  end

  assign hit_o = (n_agree >= PW'(MIN_AGREE));
endmodule

// File: rtl/fsync_arm.sv
module fsync_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic win_i,
  input  logic eol_i,
  output logic det_o
);
  logic win_q;
  logic armed;
  logic rearm;

  // re-arm acts in its own cycle so a coincident hit is taken
  assign rearm = eol_i | (win_i & ~win_q);
  assign det_o = hit_i & win_i & (armed | rearm);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= 1'b0;
      armed <= 1'b1;
    end else begin
      win_q <= win_i;
      if (det_o)      armed <= 1'b0;
      else if (rearm) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/fsync_char.sv
module fsync_char #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         det_i,
  input  logic         eol_i,
  input  logic [W-1:0] sr_nxt_i,
  output logic         line_start_o,
  output logic         byte_vld_o,
  output logic [W-1:0] byte_o
);
  localparam int unsigned CW   = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          running;
  logic [CW-1:0] cnt;
  logic          emit;

  // hit bit already counted: the first byte closes W-1 cycles later
  assign emit = running & (cnt == LAST) & ~eol_i & ~det_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running      <= 1'b0;
      cnt          <= '0;
      line_start_o <= 1'b0;
      byte_vld_o   <= 1'b0;
      byte_o       <= '0;
    end else begin
      line_start_o <= det_i;
      byte_vld_o   <= emit;
      if (emit) byte_o <= sr_nxt_i;
      if (det_i)      running <= 1'b1;
      else if (eol_i) running <= 1'b0;
      if (det_i)        cnt <= ONE;
      else if (running) cnt <= (cnt == LAST) ? '0 : cnt + ONE;
    end
  end
endmodule

// File: rtl/frame_sync_rx.sv
module frame_sync_rx
  import fsync_pkg::*;
#(
  parameter int unsigned W         = BYTE_W,
  parameter int unsigned MIN_AGREE = W - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sd_i,
  input  logic         win_i,
  input  logic         eol_i,
  input  logic [W-1:0] code_i,
  output logic         line_start_o,
  output logic         byte_vld_o,
  output logic [W-1:0] byte_o
);
  logic [W-1:0] sr;
  logic [W-1:0] sr_nxt;
  logic         hit;
  logic         det;

  fsync_shift #(.W(W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sd_i     (sd_i),
    .sr_o     (sr),
    .sr_nxt_o (sr_nxt)
  );

  fsync_match #(.W(W), .MIN_AGREE(MIN_AGREE)) u_match (
    .sr_i   (sr),
    .code_i (code_i),
    .hit_o  (hit)
  );

  fsync_arm u_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .win_i  (win_i),
    .eol_i  (eol_i),
    .det_o  (det)
  );

  fsync_char #(.W(W)) u_char (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .det_i        (det),
    .eol_i        (eol_i),
    .sr_nxt_i     (sr_nxt),
    .line_start_o (line_start_o),
    .byte_vld_o   (byte_vld_o),
    .byte_o       (byte_o)
  );
endmodule

// File: rtl/frame_sync_rx_chk.sv
module frame_sync_rx_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         win_i,
  input logic         eol_i,
  input logic         line_start_o,
  input logic         byte_vld_o,
  input logic [W-1:0] byte_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R1: assert (!line_start_o && !byte_vld_o && byte_o == '0)
        else $error("outputs active in reset");
    end
  end

  assert_vld_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  assert_closed_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_i |=> !line_start_o);

  assert_no_rearm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_o && !eol_i && !(win_i && !$past(win_i))) |=> !line_start_o);

  assert_eol_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_i |=> !byte_vld_o);

  assert_rephase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |=> !byte_vld_o);

  assert_byte_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |-> $stable(byte_o));
endmodule

bind frame_sync_rx frame_sync_rx_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .win_i        (win_i),
  .eol_i        (eol_i),
  .line_start_o (line_start_o),
  .byte_vld_o   (byte_vld_o),
  .byte_o       (byte_o)
);

// File: tb/sim_frame_sync_rx.sv
module sim_frame_sync_rx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sd_i = 1'b0;
  logic       win_i = 1'b0;
  logic       eol_i = 1'b0;
  logic [7:0] code_i = 8'hE7;
  logic       line_start_o;
  logic       byte_vld_o;
  logic [7:0] byte_o;

  frame_sync_rx u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sd_i(sd_i), .win_i(win_i), .eol_i(eol_i),
    .code_i(code_i), .line_start_o(line_start_o), .byte_vld_o(byte_vld_o),
    .byte_o(byte_o)
  );

  always #2 clk_i = ~clk_i;

  typedef struct {
    bit         is_ls;
    logic [7:0] d;
    string      tag;
  } item_t;

  item_t  exp_q[$];
  int     vectors = 0;
  int     miscompares = 0;
  int     seen = 0;
  longint cyc = 0;
  longint last_ls = -1;
  longint last_byte = -1;
  bit     fresh = 1'b0;
  string  cur = "R3";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_ls(input string tag);
    item_t it;
    it.is_ls = 1'b1; it.d = '0; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic push_byte(input logic [7:0] d, input string tag);
    item_t it;
    it.is_ls = 1'b0; it.d = d; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drive_bits(input logic [7:0] b, input int n, input logic w, input logic e0);
    for (int i = 0; i < n; i++) begin
      sd_i  = b[i];
      win_i = w;
      eol_i = e0 && (i == 0);
      @(negedge clk_i);
    end
  endtask

  task automatic run_in(input logic [7:0] pat);
    drive_bits(8'h55, 8, 1'b1, 1'b0);
    drive_bits(8'h55, 8, 1'b1, 1'b0);
    drive_bits(pat, 8, 1'b1, 1'b0);
  endtask

  // monitor: pops the scoreboard and checks strobe spacing (R7)
  always @(negedge clk_i) begin
    item_t it;
    cyc++;
    if (rst_ni) begin
      if (line_start_o) begin
        seen++;
        if (exp_q.size() == 0) chk(1'b0, cur, "unexpected line start", 1, 0);
        else begin
          it = exp_q.pop_front();
          chk(it.is_ls, it.tag, "line start where byte expected", 32'(it.d), 32'(it.d));
        end
        last_ls = cyc;
        fresh = 1'b1;
      end
      if (byte_vld_o) begin
        seen++;
        if (exp_q.size() == 0) chk(1'b0, cur, "unexpected byte", 32'(byte_o), 0);
        else begin
          it = exp_q.pop_front();
          chk(!it.is_ls && byte_o == it.d, it.tag, "byte value", 32'(byte_o), 32'(it.d));
        end
        if (fresh)
          chk(cyc - last_ls == 7, "R7", "first byte gap", 32'(cyc - last_ls), 7);
        else if (last_byte >= 0)
          chk(cyc - last_byte == 8, "R7", "byte spacing", 32'(cyc - last_byte), 8);
        fresh = 1'b0;
        last_byte = cyc;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog expired, %0d events outstanding", exp_q.size());
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk_i);
    chk(!line_start_o && !byte_vld_o && byte_o == 8'h00, "R1", "reset outputs",
        {line_start_o, byte_vld_o, byte_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // exact pattern, LSB-first bytes, eol stops timing
    cur = "R3";
    push_ls("R3"); push_byte(8'hA5, "R2"); push_byte(8'h3C, "R2"); push_byte(8'h01, "R2");
    run_in(8'hE7);
    drive_bits(8'hA5, 8, 1'b1, 1'b0);
    drive_bits(8'h3C, 8, 1'b0, 1'b0);
    drive_bits(8'h01, 8, 1'b0, 1'b0);
    cur = "R8";
    drive_bits(8'h00, 8, 1'b0, 1'b1);
    drive_bits(8'h00, 8, 1'b0, 1'b0);
    chk(seen == 4, "R8", "events after eol", 32'(seen), 4);
    chk(byte_o == 8'h01, "R11", "byte held after last strobe", 32'(byte_o), 32'h01);

    // single flipped bit, top and bottom
    cur = "R4";
    push_ls("R4"); push_byte(8'h5A, "R4"); push_byte(8'hC3, "R4");
    run_in(8'h67);
    drive_bits(8'h5A, 8, 1'b1, 1'b0);
    drive_bits(8'hC3, 8, 1'b0, 1'b0);
    drive_bits(8'h00, 8, 1'b0, 1'b1);
    push_ls("R4"); push_byte(8'h81, "R4");
    run_in(8'hE6);
    drive_bits(8'h81, 8, 1'b1, 1'b0);
    drive_bits(8'h00, 8, 1'b0, 1'b1);
    drive_bits(8'h00, 8, 1'b0, 1'b0);

    // two flipped bits: no detection
    s = seen;
    run_in(8'h66);
    drive_bits(8'h00, 8, 1'b1, 1'b0);
    drive_bits(8'h00, 8, 1'b0, 1'b1);
    drive_bits(8'h00, 8, 1'b0, 1'b0);
    chk(seen == s, "R4", "two-error pattern events", 32'(seen), 32'(s));

    // window closed: no detection
    cur = "R5";
    s = seen;
    drive_bits(8'h55, 8, 1'b0, 1'b0);
    drive_bits(8'h55, 8, 1'b0, 1'b0);
    drive_bits(8'hE7, 8, 1'b0, 1'b0);
    drive_bits(8'h00, 8, 1'b0, 1'b0);
    drive_bits(8'h00, 8, 1'b0, 1'b0);
    chk(seen == s, "R5", "closed-window events", 32'(seen), 32'(s));

    // pattern inside payload is plain data
    cur = "R6";
    push_ls("R3"); push_byte(8'hA5, "R2"); push_byte(8'hE7, "R6"); push_byte(8'h3C, "R2");
    run_in(8'hE7);
    drive_bits(8'hA5, 8, 1'b1, 1'b0);
    drive_bits(8'hE7, 8, 1'b1, 1'b0);
    drive_bits(8'h3C, 8, 1'b1, 1'b0);

    // window reopens in the hit cycle
    cur = "R9";
    push_byte(8'h00, "R9"); push_byte(8'h55, "R9"); push_byte(8'hE7, "R9");
    push_ls("R9"); push_byte(8'h99, "R9"); push_byte(8'h42, "R9");
    drive_bits(8'h00, 8, 1'b0, 1'b0);
    drive_bits(8'h55, 8, 1'b0, 1'b0);
    drive_bits(8'hE7, 8, 1'b0, 1'b0);
    drive_bits(8'h99, 8, 1'b1, 1'b0);
    drive_bits(8'h42, 8, 1'b1, 1'b0);

    // off-grid pattern with eol in the hit cycle: re-phase
    cur = "R10";
    push_byte(8'h38, "R10"); push_ls("R10"); push_byte(8'h77, "R10"); push_byte(8'h18, "R10");
    drive_bits(8'h00, 3, 1'b1, 1'b0);
    drive_bits(8'hE7, 8, 1'b1, 1'b0);
    drive_bits(8'h77, 8, 1'b1, 1'b1);
    drive_bits(8'h18, 8, 1'b1, 1'b0);
    drive_bits(8'h00, 8, 1'b0, 1'b1);
    drive_bits(8'h00, 8, 1'b0, 1'b0);

    chk(exp_q.size() == 0, "R3", "expected events outstanding", 32'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule